// File: doc/BRIEF.md
# State-Permutation Isomorph Fault Classifier

This block is a sequential checker for a small, completely specified Mealy machine. Software or a test controller loads three things through one write port: the fault-free next-state and output table, the table of the machine with a suspected fault, and a candidate renaming of states. The renaming is given as a successor array. A start pulse then launches a walk over every state/input pair. The walk decides whether the faulty machine is the fault-free machine with its states relabelled by that permutation.

When the two machines match under the renaming, the block names the kind of fault. Type A means that both the next-state table and the output table differ entry by entry. Type B means that only the next-state table differs. Type C means that only the output table differs. If the two tables are equal, the result is "identical".

Alongside the verdict, two flags report what the fault-free table alone says about the given permutation. One flag states that no type-B fault could produce it. The other states that no type-C fault could produce it.

Top module: `iso_fault_classifier`

## Requirements
- R1: Writes are accepted when `wr_en` is high. `wr_sel` chooses the target: 0 is the fault-free table, 1 is the faulty table and 2 is the successor array. For tables, `wr_addr` is {state, input}, with the state in the upper 4 bits and the input in the lower 2 bits. For tables, `wr_data` is {next state (bits 4:1), output (bit 0)}. For the successor array, the state is `wr_addr[5:2]` and the successor is `wr_data[4:1]`.
- R2: After reset, `busy`, `done`, `no_type_b` and `no_type_c` are 0, and `result` is 0.
- R3: If the successor array is not a bijection, `result` is 5 (invalid permutation) and `done` pulses one clock edge after the edge that sampled `start`. No pairs are compared in that case.
- R4: Let pred be the inverse of the successor array. The machines are isomorphic only if, for every input I and state S, both of these hold: faulty_next(I,S) = succ(good_next(I,pred(S))), and faulty_out(I,S) = good_out(I,pred(S)). Otherwise `result` is 0 (not isomorphic).
- R5: Pairs are visited with the state ascending and the input as the inner loop, at one pair per clock. The walk stops at the first failing pair, which has index m = state*4+input. `done` then pulses m+2 edges after the edge that sampled `start`.
- R6: A walk with no failing pair ends with a one-cycle `done` pulse 65 edges after the edge that sampled `start`. `busy` is high from the edge after `start` until `done`.
- R7: An isomorphic result is coded by which tables differ entry by entry. The code is 1 for identical, 2 for type A (both tables differ), 3 for type B (only the next state differs) and 4 for type C (only the output differs).
- R8: On a completed walk, `no_type_c` is 1 exactly when some pair has good_next(I,S) ≠ succ(good_next(I,pred(S))).
- R9: On a completed walk, `no_type_b` is 1 exactly when some state S with pred(S) ≠ S has good_out(I,S) ≠ good_out(I,pred(S)) for some input I.
- R10: A `start` that arrives while `busy` is high is ignored. It produces no extra `done` pulse and does not shift the timing of the walk in progress.
- R11: When `result` is 0 or 5, both `no_type_b` and `no_type_c` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 2 | Write target: 0 fault-free table, 1 faulty table, 2 successor array |
| wr_addr | input | 6 | {state, input} location |
| wr_data | input | 5 | {next state, output}; for the successor array, the upper 4 bits |
| start | input | 1 | Start pulse |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 3 | Verdict code |
| no_type_b | output | 1 | Table rules exclude a type-B fault |
| no_type_c | output | 1 | Table rules exclude a type-C fault |

## Verification
A wrong predecessor entry or a stuck pair index would show up at the ports as a wrong verdict. It would also show up as a `done` pulse arriving at the wrong edge, because the edge count from start encodes where the walk stopped. A mismatch planted at index 0, at a middle index and at the last pair therefore shows a miscounted or misordered walk within a single run. A mis-accumulated difference or feasibility bit shows up only on the final `done` of a complete walk, as a wrong type code or a wrong flag.

// File: rtl/iso_pkg.sv
`timescale 1ns/1ps
// Shared types for the isomorph fault classifier.
// Assumes result codes are decoded by software exactly as listed.
package iso_pkg;
    typedef enum logic [2:0] {
        RES_NOT_ISO  = 3'd0,
        RES_IDENT    = 3'd1,
        RES_TYPE_A   = 3'd2,
        RES_TYPE_B   = 3'd3,
        RES_TYPE_C   = 3'd4,
        RES_BAD_PERM = 3'd5
    } iso_result_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_PREP = 2'd1,
        PH_SCAN = 2'd2
    } iso_phase_e;

    localparam logic [1:0] WSEL_GOOD   = 2'd0;
    localparam logic [1:0] WSEL_FAULTY = 2'd1;
    localparam logic [1:0] WSEL_SUCC   = 2'd2;

    // Pick the fault type from the accumulated table-difference bits.
    function automatic iso_result_e classify(input logic next_d, input logic out_d);
        if (next_d && out_d) return RES_TYPE_A;
        if (next_d)          return RES_TYPE_B;
        if (out_d)           return RES_TYPE_C;
        return RES_IDENT;
    endfunction
endpackage

// File: rtl/iso_table_mem.sv
`timescale 1ns/1ps
// Register-based next-state/output table indexed by {state, input}.
// It has one write port and RD_PORTS combinational read ports.
// Assumes no write coincides with a read that must see the old value.
module iso_table_mem #(
    parameter int STATE_W  = 4,
    parameter int INPUT_W  = 2,
    parameter int OUT_W    = 1,
    parameter int RD_PORTS = 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [STATE_W+INPUT_W-1:0]  wr_addr,
    input  logic [STATE_W-1:0]          wr_next,
    input  logic [OUT_W-1:0]            wr_out,
    input  logic [STATE_W+INPUT_W-1:0]  rd_addr [RD_PORTS],
    output logic [STATE_W-1:0]          rd_next [RD_PORTS],
    output logic [OUT_W-1:0]            rd_out  [RD_PORTS]
);
    localparam int AW    = STATE_W + INPUT_W;
    localparam int DEPTH = 1 << AW;

    logic [STATE_W-1:0] nxt_q [DEPTH];
    logic [OUT_W-1:0]   out_q [DEPTH];

    // Store table entries; clear everything on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < DEPTH; k++) begin
                nxt_q[k] <= '0;
                out_q[k] <= '0;
            end
        end else if (wr_en) begin
            nxt_q[wr_addr] <= wr_next;
            out_q[wr_addr] <= wr_out;
        end
    end

    // Independent read ports, one per requester.
    for (genvar p = 0; p < RD_PORTS; p++) begin : g_rd
        assign rd_next[p] = nxt_q[rd_addr[p]];
        assign rd_out[p]  = out_q[rd_addr[p]];
    end
endmodule

// File: rtl/iso_perm_unit.sv
`timescale 1ns/1ps
// Holds the successor array and checks that it is a bijection.
// It latches the inverse (predecessor) array when asked.
// Assumes the successor array is not rewritten between latch and scan end.
module iso_perm_unit #(
    parameter int STATE_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [STATE_W-1:0] wr_state,
    input  logic [STATE_W-1:0] wr_succ,
    input  logic               latch,
    input  logic               chk_en,
    output logic               perm_ok,
    input  logic [STATE_W-1:0] succ_rd_addr,
    output logic [STATE_W-1:0] succ_rd_data,
    input  logic [STATE_W-1:0] pred_rd_addr,
    output logic [STATE_W-1:0] pred_rd_data
);
    localparam int NS = 1 << STATE_W;

    logic [STATE_W-1:0] succ_q [NS];
    logic [STATE_W-1:0] pred_q [NS];
    logic [STATE_W-1:0] pred_c [NS];
    logic [NS-1:0]      hit;

    // Successor storage; reset gives the identity renaming.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < NS; k++) succ_q[k] <= STATE_W'(k);
        end else if (wr_en) begin
            succ_q[wr_state] <= wr_succ;
        end
    end

    // Invert the mapping and record which targets are covered.
    always_comb begin
        for (int t = 0; t < NS; t++) begin
            hit[t]    = 1'b0;
            pred_c[t] = '0;
            for (int s = 0; s < NS; s++) begin
                if (succ_q[s] == STATE_W'(t)) begin
                    hit[t]    = 1'b1;
                    pred_c[t] = STATE_W'(s);
                end
            end
        end
    end

    assign perm_ok = &hit;

    // Capture the predecessor array at the preparation step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < NS; k++) pred_q[k] <= '0;
        end else if (latch) begin
            for (int k = 0; k < NS; k++) pred_q[k] <= pred_c[k];
        end
    end

    assign succ_rd_data = succ_q[succ_rd_addr];
    assign pred_rd_data = pred_q[pred_rd_addr];

    // R3: during a scan the latched predecessor inverts the successor.
    for (genvar t = 0; t < NS; t++) begin : g_inv_chk
        p_pred_inverse_r3: assert property (@(posedge clk) disable iff (!rst_n)
            chk_en |-> (succ_q[pred_q[t]] == STATE_W'(t)));
    end
endmodule

// File: rtl/iso_pair_eval.sv
`timescale 1ns/1ps
// Combinational evaluation of one state/input pair.
// It computes the isomorphism test, the entry differences and the two
// table-only feasibility conditions.
// Assumes all lookups were made with the same state and input.
module iso_pair_eval #(
    parameter int STATE_W = 4,
    parameter int OUT_W   = 1
) (
    input  logic [STATE_W-1:0] cur_state,
    input  logic [STATE_W-1:0] pred_state,
    input  logic [STATE_W-1:0] good_cur_next,
    input  logic [OUT_W-1:0]   good_cur_out,
    input  logic [OUT_W-1:0]   good_pred_out,
    input  logic [STATE_W-1:0] succ_of_pred_next,
    input  logic [STATE_W-1:0] bad_cur_next,
    input  logic [OUT_W-1:0]   bad_cur_out,
    output logic               mismatch,
    output logic               next_diff,
    output logic               out_diff,
    output logic               breaks_c,
    output logic               breaks_b
);
    // Faulty entry against the renamed fault-free entry.
    assign mismatch  = (bad_cur_next != succ_of_pred_next) ||
                       (bad_cur_out  != good_pred_out);
    // Plain entry-by-entry differences between the machines.
    assign next_diff = bad_cur_next != good_cur_next;
    assign out_diff  = bad_cur_out  != good_cur_out;
    // Condition that excludes a type-C fault.
    assign breaks_c  = good_cur_next != succ_of_pred_next;
    // Output not constant along a cycle longer than one.
    assign breaks_b  = (pred_state != cur_state) && (good_cur_out != good_pred_out);
endmodule

// File: rtl/iso_fault_classifier.sv
`timescale 1ns/1ps
// Top of the isomorph fault classifier.
// It loads two tables and a successor array, then walks every pair once
// per clock, stopping early on a mismatch, and reports a verdict code and
// two feasibility flags together with a one-cycle done pulse.
// Assumes no writes occur while busy.
module iso_fault_classifier
    import iso_pkg::*;
#(
    parameter int STATE_W = 4,
    parameter int INPUT_W = 2,
    parameter int OUT_W   = 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [1:0]                  wr_sel,
    input  logic [STATE_W+INPUT_W-1:0]  wr_addr,
    input  logic [STATE_W+OUT_W-1:0]    wr_data,
    input  logic                        start,
    output logic                        busy,
    output logic                        done,
    output logic [2:0]                  result,
    output logic                        no_type_b,
    output logic                        no_type_c
);
    localparam int ADDR_W = STATE_W + INPUT_W;
    localparam int DATA_W = STATE_W + OUT_W;

    iso_phase_e          phase_q;
    logic [ADDR_W-1:0]   idx_q;
    logic                nd_acc_q, od_acc_q, bc_acc_q, bb_acc_q;
    logic                done_q, nob_q, noc_q;
    iso_result_e         result_q;

    logic [STATE_W-1:0]  cur_state, pred_state, succ_rd;
    logic [INPUT_W-1:0]  cur_in;
    logic                perm_ok, last_pair;
    logic                mis, nd, od, bc, bb;

    logic [ADDR_W-1:0]   g_addr [2];
    logic [STATE_W-1:0]  g_next [2];
    logic [OUT_W-1:0]    g_out  [2];
    logic [ADDR_W-1:0]   f_addr [1];
    logic [STATE_W-1:0]  f_next [1];
    logic [OUT_W-1:0]    f_out  [1];

    assign cur_state = idx_q[ADDR_W-1:INPUT_W];
    assign cur_in    = idx_q[INPUT_W-1:0];
    assign last_pair = &idx_q;
    // Port 0 reads the predecessor's entry, port 1 the current entry.
    assign g_addr[0] = {pred_state, cur_in};
    assign g_addr[1] = idx_q;
    assign f_addr[0] = idx_q;

    iso_table_mem #(.STATE_W(STATE_W), .INPUT_W(INPUT_W), .OUT_W(OUT_W), .RD_PORTS(2)) u_good (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en && wr_sel == WSEL_GOOD), .wr_addr(wr_addr),
        .wr_next(wr_data[DATA_W-1:OUT_W]), .wr_out(wr_data[OUT_W-1:0]),
        .rd_addr(g_addr), .rd_next(g_next), .rd_out(g_out)
    );

    iso_table_mem #(.STATE_W(STATE_W), .INPUT_W(INPUT_W), .OUT_W(OUT_W), .RD_PORTS(1)) u_faulty (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en && wr_sel == WSEL_FAULTY), .wr_addr(wr_addr),
        .wr_next(wr_data[DATA_W-1:OUT_W]), .wr_out(wr_data[OUT_W-1:0]),
        .rd_addr(f_addr), .rd_next(f_next), .rd_out(f_out)
    );

    iso_perm_unit #(.STATE_W(STATE_W)) u_perm (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en && wr_sel == WSEL_SUCC),
        .wr_state(wr_addr[ADDR_W-1:INPUT_W]),
        .wr_succ(wr_data[DATA_W-1:OUT_W]),
        .latch(phase_q == PH_PREP),
        .chk_en(phase_q == PH_SCAN),
        .perm_ok(perm_ok),
        .succ_rd_addr(g_next[0]), .succ_rd_data(succ_rd),
        .pred_rd_addr(cur_state), .pred_rd_data(pred_state)
    );

    iso_pair_eval #(.STATE_W(STATE_W), .OUT_W(OUT_W)) u_eval (
        .cur_state(cur_state), .pred_state(pred_state),
        .good_cur_next(g_next[1]), .good_cur_out(g_out[1]),
        .good_pred_out(g_out[0]), .succ_of_pred_next(succ_rd),
        .bad_cur_next(f_next[0]), .bad_cur_out(f_out[0]),
        .mismatch(mis), .next_diff(nd), .out_diff(od),
        .breaks_c(bc), .breaks_b(bb)
    );

    // Control walk: idle, latch predecessors, then scan pairs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q  <= PH_IDLE;
            idx_q    <= '0;
            nd_acc_q <= 1'b0;
            od_acc_q <= 1'b0;
            bc_acc_q <= 1'b0;
            bb_acc_q <= 1'b0;
            done_q   <= 1'b0;
            result_q <= RES_NOT_ISO;
            nob_q    <= 1'b0;
            noc_q    <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (phase_q)
                PH_IDLE: begin
                    if (start) phase_q <= PH_PREP;
                end
                PH_PREP: begin
                    if (!perm_ok) begin
                        done_q   <= 1'b1;
                        result_q <= RES_BAD_PERM;
                        nob_q    <= 1'b0;
                        noc_q    <= 1'b0;
                        phase_q  <= PH_IDLE;
                    end else begin
                        phase_q  <= PH_SCAN;
                        idx_q    <= '0;
                        nd_acc_q <= 1'b0;
                        od_acc_q <= 1'b0;
                        bc_acc_q <= 1'b0;
                        bb_acc_q <= 1'b0;
                    end
                end
                PH_SCAN: begin
                    if (mis) begin
                        done_q   <= 1'b1;
                        result_q <= RES_NOT_ISO;
                        nob_q    <= 1'b0;
                        noc_q    <= 1'b0;
                        phase_q  <= PH_IDLE;
                    end else if (last_pair) begin
                        done_q   <= 1'b1;
                        result_q <= classify(nd_acc_q | nd, od_acc_q | od);
                        nob_q    <= bb_acc_q | bb;
                        noc_q    <= bc_acc_q | bc;
                        phase_q  <= PH_IDLE;
                    end else begin
                        idx_q    <= idx_q + 1'b1;
                        nd_acc_q <= nd_acc_q | nd;
                        od_acc_q <= od_acc_q | od;
                        bc_acc_q <= bc_acc_q | bc;
                        bb_acc_q <= bb_acc_q | bb;
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    assign busy      = phase_q != PH_IDLE;
    assign done      = done_q;
    assign result    = result_q;
    assign no_type_b = nob_q;
    assign no_type_c = noc_q;

    // R6: a done pulse only ever follows an active walk.
    p_done_after_walk_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> $past(phase_q != PH_IDLE));
    // R5: every scan begins at pair zero.
    p_scan_from_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(phase_q == PH_SCAN) |-> idx_q == '0);
    // R5: consecutive scan cycles advance by exactly one pair.
    p_scan_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_SCAN && $past(phase_q == PH_SCAN)) |-> idx_q == ADDR_W'($past(idx_q) + 1'b1));
    // R8: a type-C verdict is never paired with its exclusion flag.
    p_type_c_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && result_q == RES_TYPE_C) |-> !noc_q);
    // R9: a type-B verdict is never paired with its exclusion flag.
    p_type_b_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && result_q == RES_TYPE_B) |-> !nob_q);
    // R11: flags stay clear on rejected or failed walks.
    p_flags_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && (result_q == RES_NOT_ISO || result_q == RES_BAD_PERM)) |-> (!nob_q && !noc_q));
endmodule

// File: tb/iso_fault_classifier_bench.sv
`timescale 1ns/1ps
// Directed bench for the isomorph fault classifier.
module iso_fault_classifier_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = '0;
    logic [5:0] wr_addr = '0;
    logic [4:0] wr_data = '0;
    logic       start = 1'b0;
    logic       busy, done, no_type_b, no_type_c;
    logic [2:0] result;

    int n_checks = 0;
    int n_fail   = 0;

    int g_nx [16][4];
    int g_o  [16][4];
    int f_nx [16][4];
    int f_o  [16][4];
    int sc   [16];
    int pr   [16];

    always #4 clk = ~clk;

    iso_fault_classifier u_iso_fault_classifier (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_addr(wr_addr), .wr_data(wr_data), .start(start),
        .busy(busy), .done(done), .result(result),
        .no_type_b(no_type_b), .no_type_c(no_type_c)
    );

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    endtask

    task automatic check_eq(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input int sel, input int addr, input int data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 2'(sel); wr_addr = 6'(addr); wr_data = 5'(data);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_identity();
        for (int s = 0; s < 16; s++) sc[s] = s;
    endtask

    task automatic derive_pred();
        for (int s = 0; s < 16; s++) pr[sc[s]] = s;
    endtask

    // Faulty machine built from the renaming rule (R4).
    task automatic build_faulty();
        derive_pred();
        for (int s = 0; s < 16; s++)
            for (int i = 0; i < 4; i++) begin
                f_nx[s][i] = sc[g_nx[pr[s]][i]];
                f_o[s][i]  = g_o[pr[s]][i];
            end
    endtask

    // Load both tables and the successor array (R1 encodings).
    task automatic load_all();
        for (int s = 0; s < 16; s++)
            for (int i = 0; i < 4; i++) begin
                wr(0, s*4+i, g_nx[s][i]*2 + g_o[s][i]);
                wr(1, s*4+i, f_nx[s][i]*2 + f_o[s][i]);
            end
        for (int s = 0; s < 16; s++) wr(2, s*4, sc[s]*2);
    endtask

    // Pulse start, count edges after the sampling edge until done.
    task automatic run(output int n);
        @(negedge clk); start = 1'b1;
        @(posedge clk);
        @(negedge clk); start = 1'b0;
        n = 0;
        for (int k = 0; k < 300; k++) begin
            @(posedge clk); @(negedge clk);
            n++;
            if (done) break;
        end
    endtask

    function automatic int exp_noc();
        for (int s = 0; s < 16; s++)
            for (int i = 0; i < 4; i++)
                if (g_nx[s][i] != sc[g_nx[pr[s]][i]]) return 1;
        return 0;
    endfunction

    function automatic int exp_nob();
        for (int s = 0; s < 16; s++)
            for (int i = 0; i < 4; i++)
                if (pr[s] != s && g_o[s][i] != g_o[pr[s]][i]) return 1;
        return 0;
    endfunction

    task automatic full_case(input string name, input int exp_res);
        int n;
        load_all();
        run(n);
        check_eq({name, " R6 latency"}, n, 65);
        check_eq({name, " R7 result"}, int'(result), exp_res);
        check_eq({name, " R8 no_type_c"}, int'(no_type_c), exp_noc());
        check_eq({name, " R9 no_type_b"}, int'(no_type_b), exp_nob());
    endtask

    task automatic t_reset();
        check_eq("R2 busy", int'(busy), 0);
        check_eq("R2 done", int'(done), 0);
        check_eq("R2 result", int'(result), 0);
        check_eq("R2 flags", int'(no_type_b) + int'(no_type_c), 0);
    endtask

    task automatic t_identical();
        set_identity();
        for (int s = 0; s < 16; s++)
            for (int i = 0; i < 4; i++) begin
                g_nx[s][i] = (s*5+i) % 16; g_o[s][i] = i & 1;
            end
        build_faulty();
        full_case("identical", 1);
    endtask

    task automatic t_type_c();
        set_identity(); sc[0] = 1; sc[1] = 0;
        for (int s = 0; s < 16; s++)
            for (int i = 0; i < 4; i++) begin
                g_nx[s][i] = s; g_o[s][i] = (s ^ i) & 1;
            end
        build_faulty();
        full_case("typeC", 4);
    endtask

    task automatic t_type_b();
        set_identity(); sc[0] = 1; sc[1] = 0;
        for (int s = 0; s < 16; s++)
            for (int i = 0; i < 4; i++) begin
                g_nx[s][i] = (s+1+i) % 16; g_o[s][i] = (s >= 8) ? 1 : 0;
            end
        build_faulty();
        full_case("typeB", 3);
    endtask

    task automatic setup_type_a();
        set_identity(); sc[0] = 1; sc[1] = 0; sc[2] = 3; sc[3] = 4; sc[4] = 2;
        for (int s = 0; s < 16; s++)
            for (int i = 0; i < 4; i++) begin
                g_nx[s][i] = (s*3+i) % 16; g_o[s][i] = (s ^ i) & 1;
            end
        build_faulty();
    endtask

    task automatic t_type_a();
        setup_type_a();
        full_case("typeA", 2);
    endtask

    // Mismatch planted at pair (s,i): R4 verdict, R5 stop point, R11 flags.
    task automatic t_mismatch(input string name, input int s, input int i, input bit out_bit);
        int n;
        if (out_bit) f_o[s][i] = f_o[s][i] ^ 1;
        else         f_nx[s][i] = f_nx[s][i] ^ 1;
        wr(1, s*4+i, f_nx[s][i]*2 + f_o[s][i]);
        run(n);
        check_eq({name, " R4 result"}, int'(result), 0);
        check_eq({name, " R5 stop latency"}, n, s*4+i+2);
        check_eq({name, " R11 flags"}, int'(no_type_b) + int'(no_type_c), 0);
        if (out_bit) f_o[s][i] = f_o[s][i] ^ 1;
        else         f_nx[s][i] = f_nx[s][i] ^ 1;
        wr(1, s*4+i, f_nx[s][i]*2 + f_o[s][i]);
    endtask

    task automatic t_bad_perm();
        int n;
        set_identity(); sc[5] = 3;
        for (int s = 0; s < 16; s++) wr(2, s*4, sc[s]*2);
        run(n);
        check_eq("R3 result", int'(result), 5);
        check_eq("R3 latency", n, 1);
        check_eq("R11 bad perm flags", int'(no_type_b) + int'(no_type_c), 0);
    endtask

    task automatic t_start_busy();
        int n, extra;
        setup_type_a();
        load_all();
        @(negedge clk); start = 1'b1;
        @(posedge clk);
        @(negedge clk); start = 1'b0;
        n = 0; extra = 0;
        for (int k = 0; k < 300; k++) begin
            @(posedge clk); @(negedge clk);
            n++;
            if (n == 2) check_eq("R6 busy during walk", int'(busy), 1);
            if (n == 10) start = 1'b1;
            if (n == 11) start = 1'b0;
            if (done) break;
        end
        check_eq("R10 latency with extra start", n, 65);
        check_eq("R10 result", int'(result), 2);
        for (int k = 0; k < 70; k++) begin
            @(posedge clk); @(negedge clk);
            if (done) extra++;
        end
        check_eq("R10 no extra done", extra, 0);
        check_eq("R6 idle after done", int'(busy), 0);
    endtask

    initial begin
        #(8 * 150000);
        n_checks++; n_fail++;
        $display("FAIL watchdog R6 actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_identical();
        t_type_a();
        t_type_b();
        t_type_c();
        setup_type_a();
        load_all();
        t_mismatch("mid", 5, 2, 1'b0);
        t_mismatch("first", 0, 0, 1'b1);
        t_mismatch("last", 15, 3, 1'b1);
        t_bad_perm();
        t_start_busy();
        summary();
        $finish;
    end
endmodule